// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block selects the operating mode of a small microcontroller core and drives the clock and oscillator controls that go with each mode. Software sets a handful of policy fields. A one-cycle wait-for-interrupt pulse then moves the core from RUN into a light sleep or into one of three deep-sleep levels. In light sleep only the CPU clock stops. The deep levels are a stop mode with the oscillator at full speed, at 4 MHz or off; a standby mode with an optional gate on the main clock; and a shutdown request.

Two policy fields, oscillator off and low-frequency main clock, act on the outputs at once, including in RUN. The deep-sleep fields (4 MHz in stop, oscillator off in stop, main clock gate in standby) are copied into a shadow on the wait-for-interrupt pulse. Only that shadow shapes the low-power sub-mode, so writes made while asleep have no effect. A wake interrupt returns the block to RUN from sleep, stop or standby. Shutdown is left only through reset.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in RUN: `mode_onehot`=5'b00001, `cpu_clk_en`=1, `osc_en`=1, and `osc_4m_sel`, `lf_main_sel`, `main_clk_gate`, `shutdown_req` are 0. The bits of `mode_onehot` are 0=RUN, 1=SLEEP, 2=STOP, 3=STANDBY, 4=SHUTDOWN.
- R2: A `wfi_pulse` in RUN with `sleep_deep`=0 and no `wake_irq` gives SLEEP one cycle later. `cpu_clk_en` drops to 0 and the other outputs stay as in RUN.
- R3: A `wfi_pulse` in RUN with `sleep_deep`=1 and no `wake_irq` selects the mode from `deep_lvl`: 2'b00 gives STOP, 2'b01 gives STANDBY, 2'b10 gives SHUTDOWN, and the reserved 2'b11 gives STOP.
- R4: In RUN and SLEEP, `osc_en` equals the inverse of `cfg_osc_off` and `lf_main_sel` equals `cfg_lf_main`, both as sampled at the previous clock edge.
- R5: In STOP, `osc_en` is 0 when the live `cfg_osc_off` is set or the captured oscillator-off-in-stop bit is set, and 1 otherwise. `osc_4m_sel` is 1 only when the oscillator is on and the captured 4 MHz bit is set. `lf_main_sel` follows `cfg_lf_main`.
- R6: In STANDBY, `osc_en` is 0 and `main_clk_gate` equals the captured standby gate bit. In SHUTDOWN, `shutdown_req` is 1 and `osc_en` is 0. `cpu_clk_en` is 0 in every mode except RUN.
- R7: `wake_irq` in SLEEP, STOP or STANDBY gives RUN one cycle later. The CPU clock is enabled again, and the oscillator and clock-select outputs come from the live policy bits.
- R8: SHUTDOWN ignores `wake_irq` and `wfi_pulse` and is left only by reset.
- R9: Changes to `cfg_stop_4m`, `cfg_stop_osc_off` or `cfg_stby_gate` after entry into a low-power mode do not change that mode's outputs.
- R10: A `wfi_pulse` that comes in the same cycle as `wake_irq` leaves the block in RUN.
- R11: A `wfi_pulse` outside RUN is ignored.
- R12: Exactly one bit of `mode_onehot` is set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_osc_off | input | 1 | Oscillator off now (acts immediately) |
| cfg_lf_main | input | 1 | Main clock from low-frequency source (acts immediately) |
| cfg_stop_4m | input | 1 | Oscillator at 4 MHz in STOP |
| cfg_stop_osc_off | input | 1 | Oscillator off in STOP only |
| cfg_stby_gate | input | 1 | Gate main clock in STANDBY |
| deep_lvl | input | 2 | Deep-sleep level |
| sleep_deep | input | 1 | Wait-for-interrupt selects a deep level |
| wfi_pulse | input | 1 | One-cycle wait-for-interrupt request |
| wake_irq | input | 1 | Wake interrupt |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | System oscillator enable |
| osc_4m_sel | output | 1 | Oscillator at 4 MHz |
| lf_main_sel | output | 1 | Main clock from low-frequency source |
| main_clk_gate | output | 1 | Main clock gated (standby) |
| shutdown_req | output | 1 | Shutdown request |
| mode_onehot | output | 5 | Current mode, one-hot |

## Verification
On every cycle the assertions check the one-hot mode, the light-sleep entry, the wake return, the priority of wake over a simultaneous wait-for-interrupt, the hold in shutdown, and the tracking of the two immediate bits in RUN. They also check that the standby oscillator is off and that 4 MHz is selected only in STOP with the oscillator on. Only the bench scenarios show the shadow behaviour: sub-mode outputs stay fixed while the deep-sleep fields change during sleep. The same holds for the mapping of each deep level and sub-mode combination, and for the exit from shutdown through reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NUM_MODES = 5;
  localparam int MODE_W    = 3;
  localparam int LVL_W     = 2;

  localparam logic [LVL_W-1:0] LVL_STOP  = 2'b00;
  localparam logic [LVL_W-1:0] LVL_STBY  = 2'b01;
  localparam logic [LVL_W-1:0] LVL_SDOWN = 2'b10;

  typedef enum logic [MODE_W-1:0] {
    M_RUN   = 3'd0,
    M_SLEEP = 3'd1,
    M_STOP  = 3'd2,
    M_STBY  = 3'd3,
    M_SDOWN = 3'd4
  } lpm_mode_e;

  typedef struct packed {
    logic stop_4m;
    logic stop_off;
    logic stby_gate;
  } lpm_shadow_t;
endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wfi_pulse,
  input  logic          wake_irq,
  input  logic          sleep_deep,
  input  logic [LW-1:0] deep_lvl,
  output lpm_mode_e     mode_q,
  output logic          capture
);
  lpm_mode_e mode_d;

  // wait-for-interrupt honoured only in RUN and only without a pending wake
  assign capture = (mode_q == M_RUN) && wfi_pulse && !wake_irq;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_RUN: begin
        if (capture) begin
          if (!sleep_deep)              mode_d = M_SLEEP;
          else if (deep_lvl == LVL_SDOWN) mode_d = M_SDOWN;
          else if (deep_lvl == LVL_STBY)  mode_d = M_STBY;
          else                            mode_d = M_STOP;
        end
      end
      M_SLEEP, M_STOP, M_STBY: begin
        if (wake_irq) mode_d = M_RUN;
      end
      M_SDOWN: mode_d = M_SDOWN;
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_RUN;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/lpm_policy_regs.sv
module lpm_policy_regs
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        cfg_osc_off,
  input  logic        cfg_lf_main,
  input  logic        cfg_stop_4m,
  input  logic        cfg_stop_osc_off,
  input  logic        cfg_stby_gate,
  output logic        live_off_q,
  output logic        live_lf_q,
  output lpm_shadow_t shadow_q
);
  lpm_shadow_t shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    if (capture) begin
      shadow_d.stop_4m   = cfg_stop_4m;
      shadow_d.stop_off  = cfg_stop_osc_off;
      shadow_d.stby_gate = cfg_stby_gate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_off_q <= 1'b0;
      live_lf_q  <= 1'b0;
      shadow_q   <= '0;
    end else begin
      live_off_q <= cfg_osc_off;
      live_lf_q  <= cfg_lf_main;
      shadow_q   <= shadow_d;
    end
  end
endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
  import lpm_pkg::*;
(
  input  lpm_mode_e             mode_q,
  input  logic                  live_off_q,
  input  logic                  live_lf_q,
  input  lpm_shadow_t           shadow_q,
  output logic                  cpu_clk_en,
  output logic                  osc_en,
  output logic                  osc_4m_sel,
  output logic                  lf_main_sel,
  output logic                  main_clk_gate,
  output logic                  shutdown_req,
  output logic [NUM_MODES-1:0]  mode_onehot
);
  logic run_like, in_stop;

  assign run_like = (mode_q == M_RUN) || (mode_q == M_SLEEP);
  assign in_stop  = (mode_q == M_STOP);

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_onehot
    assign mode_onehot[i] = (mode_q == MODE_W'(i));
  end

  always_comb begin
    cpu_clk_en    = (mode_q == M_RUN);
    if (run_like)     osc_en = !live_off_q;
    else if (in_stop) osc_en = !(live_off_q || shadow_q.stop_off);
    else              osc_en = 1'b0;
    osc_4m_sel    = in_stop && osc_en && shadow_q.stop_4m;
    lf_main_sel   = (run_like || in_stop) && live_lf_q;
    main_clk_gate = (mode_q == M_STBY) && shadow_q.stby_gate;
    shutdown_req  = (mode_q == M_SDOWN);
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_osc_off,
  input  logic                 cfg_lf_main,
  input  logic                 cfg_stop_4m,
  input  logic                 cfg_stop_osc_off,
  input  logic                 cfg_stby_gate,
  input  logic [LVL_W-1:0]     deep_lvl,
  input  logic                 sleep_deep,
  input  logic                 wfi_pulse,
  input  logic                 wake_irq,
  output logic                 cpu_clk_en,
  output logic                 osc_en,
  output logic                 osc_4m_sel,
  output logic                 lf_main_sel,
  output logic                 main_clk_gate,
  output logic                 shutdown_req,
  output logic [NUM_MODES-1:0] mode_onehot
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  lpm_mode_e              mode_q;
  logic                   capture;
  logic                   live_off_q, live_lf_q;
  lpm_shadow_t            shadow_q;

  // asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .wfi_pulse(wfi_pulse), .wake_irq(wake_irq),
    .sleep_deep(sleep_deep), .deep_lvl(deep_lvl), .mode_q(mode_q), .capture(capture)
  );

  lpm_policy_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .capture(capture),
    .cfg_osc_off(cfg_osc_off), .cfg_lf_main(cfg_lf_main),
    .cfg_stop_4m(cfg_stop_4m), .cfg_stop_osc_off(cfg_stop_osc_off),
    .cfg_stby_gate(cfg_stby_gate),
    .live_off_q(live_off_q), .live_lf_q(live_lf_q), .shadow_q(shadow_q)
  );

  lpm_out_decode u_dec (
    .mode_q(mode_q), .live_off_q(live_off_q), .live_lf_q(live_lf_q),
    .shadow_q(shadow_q), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .osc_4m_sel(osc_4m_sel), .lf_main_sel(lf_main_sel),
    .main_clk_gate(main_clk_gate), .shutdown_req(shutdown_req),
    .mode_onehot(mode_onehot)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_osc_off,
  input logic       cfg_lf_main,
  input logic       sleep_deep,
  input logic       wfi_pulse,
  input logic       wake_irq,
  input logic       cpu_clk_en,
  input logic       osc_en,
  input logic       osc_4m_sel,
  input logic       lf_main_sel,
  input logic       shutdown_req,
  input logic [4:0] mode_onehot
);
  p_one_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_onehot) == 1);

  p_light_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_onehot[0] && wfi_pulse && !wake_irq && !sleep_deep
      |=> mode_onehot[1] && !cpu_clk_en);

  p_wake_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_onehot[1] || mode_onehot[2] || mode_onehot[3]) && wake_irq
      |=> mode_onehot[0] && cpu_clk_en);

  p_wake_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_onehot[0] && wake_irq |=> mode_onehot[0]);

  p_sdown_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_onehot[4] |=> mode_onehot[4] && shutdown_req && !osc_en);

  p_live_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_onehot[0] && !wfi_pulse
      |=> (osc_en == !$past(cfg_osc_off)) && (lf_main_sel == $past(cfg_lf_main)));

  p_stby_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_onehot[3] |-> !osc_en && !cpu_clk_en);

  p_4m_stop_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_4m_sel |-> mode_onehot[2] && osc_en);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .cfg_osc_off(cfg_osc_off), .cfg_lf_main(cfg_lf_main),
  .sleep_deep(sleep_deep), .wfi_pulse(wfi_pulse), .wake_irq(wake_irq),
  .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .osc_4m_sel(osc_4m_sel),
  .lf_main_sel(lf_main_sel), .shutdown_req(shutdown_req), .mode_onehot(mode_onehot)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic osc_off, lf, s4m, soff, sgate, sdeep, wfi, wake;
  logic [1:0] lvl;
  logic cpu_en, osc_en, f4, lfsel, gate, sdreq;
  logic [4:0] mode;

  always #5 clk = ~clk;

  lpm_ctrl i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_osc_off(osc_off), .cfg_lf_main(lf),
    .cfg_stop_4m(s4m), .cfg_stop_osc_off(soff), .cfg_stby_gate(sgate),
    .deep_lvl(lvl), .sleep_deep(sdeep), .wfi_pulse(wfi), .wake_irq(wake),
    .cpu_clk_en(cpu_en), .osc_en(osc_en), .osc_4m_sel(f4), .lf_main_sel(lfsel),
    .main_clk_gate(gate), .shutdown_req(sdreq), .mode_onehot(mode)
  );

  // behavioural reference: mode index 0 RUN,1 SLEEP,2 STOP,3 STANDBY,4 SHUTDOWN
  integer m_mode;
  bit m_off, m_lf, m_s4m, m_soff, m_gate;
  integer vecs = 0, errs = 0;
  bit checking = 0;
  string cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_off = 0; m_lf = 0; m_s4m = 0; m_soff = 0; m_gate = 0;
    end else begin
      if (m_mode == 0) begin
        if (wfi && !wake) begin
          m_s4m = s4m; m_soff = soff; m_gate = sgate;
          if (!sdeep)          m_mode = 1;
          else if (lvl == 2'b10) m_mode = 4;
          else if (lvl == 2'b01) m_mode = 3;
          else                 m_mode = 2;
        end
      end else if (m_mode != 4 && wake) m_mode = 0;
      m_off = osc_off; m_lf = lf;
    end
  end

  task automatic compare();
    logic [10:0] exp_v, act_v;
    bit e_osc;
    if (m_mode <= 1)      e_osc = !m_off;
    else if (m_mode == 2) e_osc = !(m_off || m_soff);
    else                  e_osc = 1'b0;
    exp_v[4:0] = 5'b1 << m_mode;
    exp_v[5]   = (m_mode == 0);
    exp_v[6]   = e_osc;
    exp_v[7]   = (m_mode == 2) && e_osc && m_s4m;
    exp_v[8]   = (m_mode <= 2) && m_lf;
    exp_v[9]   = (m_mode == 3) && m_gate;
    exp_v[10]  = (m_mode == 4);
    act_v = {sdreq, gate, lfsel, f4, osc_en, cpu_en, mode};
    vecs++;
    if (act_v !== exp_v) begin
      errs++;
      $display("FAIL %s: outputs actual %b expected %b at %0t", cur_req, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (checking) compare();

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_wfi(bit deep, logic [1:0] l);
    sdeep = deep; lvl = l; wfi = 1; tick(); wfi = 0;
  endtask

  task automatic do_wake();
    wake = 1; tick(); wake = 0;
  endtask

  task automatic apply_reset();
    checking = 0;
    rst_n = 0;
    {osc_off, lf, s4m, soff, sgate, sdeep, wfi, wake} = '0; lvl = 2'b00;
    tick(4); rst_n = 1; tick(3);
    checking = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    apply_reset();
    // R1: explicit reset state
    @(negedge clk);
    vecs++;
    if ({sdreq, gate, lfsel, f4, osc_en, cpu_en, mode} !== 11'b000_0011_0000_1 >> 0 &&
        {sdreq, gate, lfsel, f4, osc_en, cpu_en, mode} !== {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,5'b00001}) begin
      errs++;
      $display("FAIL R1: reset actual %b expected %b", {sdreq, gate, lfsel, f4, osc_en, cpu_en, mode},
               {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,5'b00001});
    end
    #1;
    cur_req = "R4"; // immediate bits in RUN
    lf = 1; tick(2); osc_off = 1; tick(2); lf = 0; tick(); osc_off = 0; tick(2);
    cur_req = "R2"; lf = 1; do_wfi(0, 2'b11); tick(3);
    cur_req = "R4"; osc_off = 1; tick(2); osc_off = 0; tick();
    cur_req = "R7"; do_wake(); tick(2);
    cur_req = "R3"; lf = 0; do_wfi(1, 2'b00); tick(2);          // STOP0
    cur_req = "R7"; do_wake(); tick();
    cur_req = "R5"; s4m = 1; do_wfi(1, 2'b00); tick(2);        // STOP1
    cur_req = "R9"; s4m = 0; soff = 1; tick(3);                // shadow holds
    cur_req = "R7"; do_wake(); tick();
    cur_req = "R5"; s4m = 1; soff = 1; do_wfi(1, 2'b00); tick(2); // STOP2 via stop bit
    cur_req = "R7"; do_wake(); tick(2);
    cur_req = "R5"; soff = 0; s4m = 0; osc_off = 1; do_wfi(1, 2'b00); tick(2); // STOP2 via disable
    osc_off = 0; tick(2);
    cur_req = "R7"; do_wake(); tick();
    cur_req = "R3"; s4m = 1; do_wfi(1, 2'b11); tick(2);        // reserved level acts as STOP
    do_wake(); s4m = 0;
    cur_req = "R6"; sgate = 0; do_wfi(1, 2'b01); tick(2);      // STANDBY0
    cur_req = "R9"; sgate = 1; tick(2);
    cur_req = "R11"; do_wfi(0, 2'b00); tick(2);
    cur_req = "R7"; do_wake(); tick();
    cur_req = "R6"; do_wfi(1, 2'b01); tick(2);                 // STANDBY1
    cur_req = "R9"; sgate = 0; tick(2);
    cur_req = "R7"; do_wake(); tick();
    cur_req = "R10"; sdeep = 0; wake = 1; wfi = 1; tick(); wfi = 0; wake = 0; tick(2);
    sdeep = 1; lvl = 2'b01; wake = 1; wfi = 1; tick(); wfi = 0; wake = 0; tick(2);
    cur_req = "R11"; do_wfi(0, 2'b00); tick(); do_wfi(1, 2'b10); tick(2);
    do_wake(); tick();
    cur_req = "R6"; do_wfi(1, 2'b10); tick(2);                 // SHUTDOWN
    cur_req = "R8"; do_wake(); tick(); do_wake(); do_wfi(0, 2'b00); tick(3);
    cur_req = "R12"; tick(2);
    cur_req = "R1"; apply_reset(); tick(3);
    cur_req = "R2"; do_wfi(0, 2'b10); tick(2); do_wake(); tick(2);
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule